// File: doc/BRIEF.md
# SD Card Command Issue and Response Engine

This block runs the command phase of an SD/MMC card bus. Software first writes a 32-bit argument, then a command word. The command-word write launches a 48-bit frame on the CMD line. The frame holds a start bit 0, a transmission bit 1, the 6-bit index, the argument, a CRC7 and an end bit 1. The engine then listens for the response type named in the command word. A 48-bit or 136-bit token is collected and its CRC is checked. The useful bits go into four 32-bit response registers, and the command-status word records how the command ended.

A separate divider block supplies two one-cycle strobes in the system clock domain: one marks the falling edge of the card clock and one marks the rising edge. The engine changes CMD only on the falling strobe. It samples CMD and DAT0 only on the rising strobe. A busy-signalling response holds the engine in a second busy state until the card releases DAT0. Reading the status word clears it.

Top module: `sdcmd_engine`

## Requirements
- R1: A pulse on `arg_wr` stores `arg_data`. A pulse on `cmd_wr` while idle launches a frame built from the most recently stored argument and `cmd_word`. Command word fields: index in bits 5:0, abort in bit 6, response kind in bits 9:7, data kind in bits 12:11, direction in bit 13, stop in bit 14. The last three have no effect in this block.
- R2: The frame is sent MSB first as {0, 1, index, argument, CRC7, 1}. The CRC7 uses polynomial x^7+x^3+1 with a zero start value and covers the first 40 frame bits. Index 0 with argument 0 gives 48'h400000000095.
- R3: `cmd_out` changes only on a cycle marked by `fall_stb`. `cmd_oe` is high for exactly 48 bit periods per frame. Response bits are taken from `cmd_in` on `rise_stb`.
- R4: `ctl_sta` bit 1 (command busy) is high from the cycle after launch until the command phase ends. Bit 0 is the OR of bits 1 and 4. Bits 3:2 read 0. Status bits only rise while the engine is idle.
- R5: Response kind 0 expects no response. Command-ready (status bit 0) is set after `GAP_CLKS` rising strobes (default 8) following the end bit.
- R6: Kinds 1, 3, 4, 5, 6 and 7 take a 48-bit token. Token bits 39:8 go into `resp0`, and `resp1` to `resp3` keep their values.
- R7: Kind 2 takes a 136-bit token. Token bits 127:0 are stored with bits 31:0 in `resp0` up to bits 127:96 in `resp3`. Its CRC7 covers token bits 127:8.
- R8: When the received CRC7 (token bits 7:1) does not match, the command ends with the CRC-error flag (status bit 2) and without command-ready. Kind 3 is never checked.
- R9: If no start bit arrives within `TO_CLKS` rising strobes (default 64) after the frame, the command ends with the timeout flag (status bit 1) and without command-ready.
- R10: For kind 7 with a good response, `ctl_sta` bit 4 stays high and bit 1 low until DAT0 is sampled high on a rising strobe. Command-ready is then set.
- R11: A good kind-5 response sets the card-interrupt flag (status bit 3) together with command-ready.
- R12: `stat_word` holds the four sticky flags. A `status_rd` pulse clears them.
- R13: A `cmd_wr` while busy is ignored unless abort bit 6 is set. When it is set, the engine releases CMD, returns to idle and sets no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rise_stb | input | 1 | Card-clock rising-edge strobe |
| fall_stb | input | 1 | Card-clock falling-edge strobe |
| arg_wr | input | 1 | Argument write pulse |
| arg_data | input | 32 | Argument value |
| cmd_wr | input | 1 | Command word write pulse |
| cmd_word | input | 16 | Command word |
| status_rd | input | 1 | Status read pulse, clears flags |
| cmd_in | input | 1 | CMD line as seen from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| stat_word | output | 4 | Ready, timeout, CRC error, card interrupt |
| ctl_sta | output | 5 | Any busy, command busy, 0, 0, release-wait busy |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
The bench builds the engine with `TO_CLKS` = 16 and `GAP_CLKS` = 4. This makes the timeout window and the idle gap after a no-response command short enough to count exactly, strobe by strobe. Under these values a full no-response run, a timeout and a long release wait on DAT0 all fit in a few hundred cycles each. This leaves room to probe the ignored and aborting command writes at chosen points inside a frame.

// File: rtl/sdcmd_pkg.sv
// Shared types, field positions and the CRC7 helper for the command engine.
// Assumes a 16-bit command word and the fixed 48-bit command frame.
package sdcmd_pkg;

    localparam int ARG_W     = 32;
    localparam int CW_W      = 16;
    localparam int FRAME_W   = 48;
    localparam int SHORT_W   = 48;
    localparam int LONG_W    = 136;
    localparam int CRC_W     = 7;
    localparam int HDR_W     = FRAME_W - CRC_W - 1;

    localparam int CW_BRK    = 6;
    localparam int CW_KIND_L = 7;

    localparam int ST_READY  = 0;
    localparam int ST_TMO    = 1;
    localparam int ST_CRC    = 2;
    localparam int ST_CIRQ   = 3;

    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_R1   = 3'd1,
        KIND_R2   = 3'd2,
        KIND_R3   = 3'd3,
        KIND_R4   = 3'd4,
        KIND_R5   = 3'd5,
        KIND_R6   = 3'd6,
        KIND_R1B  = 3'd7
    } rsp_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_GAP,
        S_RESP,
        S_RELW
    } eng_state_e;

    // One serial step of the x^7 + x^3 + 1 checksum.
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                   input logic b);
        logic fb;
        logic [CRC_W-1:0] n;
        fb   = b ^ c[6];
        n[0] = fb;
        n[1] = c[0];
        n[2] = c[1];
        n[3] = c[2] ^ fb;
        n[4] = c[3];
        n[5] = c[4];
        n[6] = c[5];
        return n;
    endfunction

    // Checksum of a whole frame header, MSB first.
    function automatic logic [CRC_W-1:0] crc7_hdr(input logic [HDR_W-1:0] h);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            c = crc7_step(c, h[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
// Serial CRC7 accumulator. Clear has priority over a bit update.
// Assumes one bit per enabled cycle, MSB of the covered field first.
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);

    // Accumulate the checksum over the enabled bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, bit_in);
        end
    end

endmodule

// File: rtl/sdcmd_tx.sv
// Frame shifter for the CMD line. Drives one bit per falling strobe, MSB
// first, and releases the line on the falling strobe after the last bit.
// Assumes load only arrives while inactive; cancel has priority over all.
module sdcmd_tx
    import sdcmd_pkg::*;
#(
    parameter int W = FRAME_W
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] frame,
    input  logic         fall_stb,
    input  logic         cancel,
    output logic         line,
    output logic         oe,
    output logic         done
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] sent_q;
    logic             act_q;

    // Shift the frame out and flag the release of the line.
    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (!rst_n || cancel) begin
            act_q  <= 1'b0;
            oe     <= 1'b0;
            line   <= 1'b1;
            sent_q <= '0;
            sh_q   <= '0;
        end else if (load) begin
            sh_q   <= frame;
            sent_q <= '0;
            act_q  <= 1'b1;
        end else if (act_q && fall_stb) begin
            if (sent_q == CNT_W'(W)) begin
                oe    <= 1'b0;
                line  <= 1'b1;
                act_q <= 1'b0;
                done  <= 1'b1;
            end else begin
                line   <= sh_q[W-1];
                oe     <= 1'b1;
                sh_q   <= {sh_q[W-2:0], 1'b0};
                sent_q <= sent_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdcmd_rx.sv
// Response collector. Once armed, it waits for a low start bit on a rising
// strobe, then shifts in a short or long token and checks its CRC7.
// Assumes arm and cancel are single-cycle; cancel wins over arm.
module sdcmd_rx
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              cancel,
    input  logic              long_mode,
    input  logic              crc_skip,
    input  logic              rise_stb,
    input  logic              line,
    output logic              started,
    output logic              done,
    output logic              crc_bad,
    output logic [LONG_W-1:0] token
);

    localparam int CNT_W   = $clog2(LONG_W + 1);
    localparam int S_LO    = 0;
    localparam int S_HI    = SHORT_W - 9;
    localparam int L_LO    = 8;
    localparam int L_HI    = LONG_W - 9;

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] win_lo;
    logic [CNT_W-1:0] win_hi;
    logic             take;
    logic             in_win;
    logic [CRC_W-1:0] crc_acc;

    // Pick the token length and the checksum window for the kind.
    always_comb begin
        last_idx = long_mode ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);
        win_lo   = long_mode ? CNT_W'(L_LO) : CNT_W'(S_LO);
        win_hi   = long_mode ? CNT_W'(L_HI) : CNT_W'(S_HI);
        take     = armed_q && rise_stb && (started || !line);
        in_win   = (cnt_q >= win_lo) && (cnt_q <= win_hi);
    end

    sdcmd_crc7 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (arm),
        .en     (take && in_win),
        .bit_in (line),
        .crc    (crc_acc)
    );

    // Shift in token bits and pulse done after the last one.
    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (!rst_n) begin
            armed_q <= 1'b0;
            started <= 1'b0;
            cnt_q   <= '0;
            token   <= '0;
        end else if (cancel) begin
            armed_q <= 1'b0;
            started <= 1'b0;
        end else if (arm) begin
            armed_q <= 1'b1;
            started <= 1'b0;
            cnt_q   <= '0;
        end else if (take) begin
            token   <= {token[LONG_W-2:0], line};
            cnt_q   <= cnt_q + 1'b1;
            started <= 1'b1;
            if (cnt_q == last_idx) begin
                armed_q <= 1'b0;
                started <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    // Compare the accumulated checksum with the received field.
    assign crc_bad = !crc_skip && (crc_acc != token[CRC_W:1]);

endmodule

// File: rtl/sdcmd_engine.sv
// Command phase controller for an SD/MMC card bus. It builds and sends
// a command frame, waits for the selected response, stores it and records
// the outcome in a read-to-clear status word.
// Assumes rise_stb and fall_stb are one-cycle pulses that never coincide.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TO_CLKS  = 64,
    parameter int GAP_CLKS = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             arg_wr,
    input  logic [ARG_W-1:0] arg_data,
    input  logic             cmd_wr,
    input  logic [CW_W-1:0]  cmd_word,
    input  logic             status_rd,
    input  logic             cmd_in,
    input  logic             dat0_in,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic [3:0]       stat_word,
    output logic [4:0]       ctl_sta,
    output logic [31:0]      resp0,
    output logic [31:0]      resp1,
    output logic [31:0]      resp2,
    output logic [31:0]      resp3
);

    localparam int CNT_MAX  = (TO_CLKS > GAP_CLKS) ? TO_CLKS : GAP_CLKS;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int N_WORDS  = 4;

    eng_state_e        state_q;
    rsp_kind_e         kind_q;
    rsp_kind_e         kind_in;
    logic [ARG_W-1:0]  arg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [3:0]        set_bits;
    logic [31:0]       resp_q [N_WORDS];

    logic              idle;
    logic              launch;
    logic              abort;
    logic              tmo_hit;
    logic [HDR_W-1:0]  header;
    logic [FRAME_W-1:0] frame;

    logic              tx_done;
    logic              rx_arm;
    logic              rx_cancel;
    logic              rx_started;
    logic              rx_done;
    logic              rx_crc_bad;
    logic [LONG_W-1:0] token;

    logic              unused_cw_bits;

    // Decode the request and assemble the outgoing frame (R1, R2).
    always_comb begin
        idle    = (state_q == S_IDLE);
        kind_in = rsp_kind_e'(cmd_word[CW_KIND_L +: 3]);
        launch  = idle && cmd_wr;
        abort   = !idle && cmd_wr && cmd_word[CW_BRK];
        header  = {1'b0, 1'b1, cmd_word[5:0], arg_q};
        frame   = {header, crc7_hdr(header), 1'b1};
        tmo_hit = (state_q == S_RESP) && rise_stb && !rx_started && cmd_in
                  && (cnt_q == CNT_W'(TO_CLKS - 1));
        rx_arm  = (state_q == S_SEND) && tx_done && (kind_q != KIND_NONE);
        rx_cancel = abort || tmo_hit;
    end

    // Data kind, direction and stop fields are carried but unused here.
    assign unused_cw_bits = ^{cmd_word[15:10], token[LONG_W-1:128]};

    sdcmd_tx #(.W(FRAME_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .frame    (frame),
        .fall_stb (fall_stb),
        .cancel   (abort),
        .line     (cmd_out),
        .oe       (cmd_oe),
        .done     (tx_done)
    );

    sdcmd_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (rx_arm),
        .cancel    (rx_cancel),
        .long_mode (kind_q == KIND_R2),
        .crc_skip  (kind_q == KIND_R3),
        .rise_stb  (rise_stb),
        .line      (cmd_in),
        .started   (rx_started),
        .done      (rx_done),
        .crc_bad   (rx_crc_bad),
        .token     (token)
    );

    // Work out which status flags this cycle raises (R5, R8-R11).
    always_comb begin
        set_bits = '0;
        case (state_q)
            S_GAP: begin
                if (rise_stb && cnt_q == CNT_W'(GAP_CLKS - 1)) begin
                    set_bits[ST_READY] = 1'b1;
                end
            end
            S_RESP: begin
                if (tmo_hit) begin
                    set_bits[ST_TMO] = 1'b1;
                end else if (rx_done) begin
                    if (rx_crc_bad) begin
                        set_bits[ST_CRC] = 1'b1;
                    end else if (kind_q != KIND_R1B) begin
                        set_bits[ST_READY] = 1'b1;
                        set_bits[ST_CIRQ]  = (kind_q == KIND_R5);
                    end
                end
            end
            S_RELW: begin
                if (rise_stb && dat0_in) begin
                    set_bits[ST_READY] = 1'b1;
                end
            end
            default: set_bits = '0;
        endcase
        if (abort) begin
            set_bits = '0;
        end
    end

    // Sequence the command phase through its states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= KIND_NONE;
            cnt_q   <= '0;
        end else if (abort) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (launch) begin
                        state_q <= S_SEND;
                        kind_q  <= kind_in;
                    end
                end
                S_SEND: begin
                    if (tx_done) begin
                        cnt_q   <= '0;
                        state_q <= (kind_q == KIND_NONE) ? S_GAP : S_RESP;
                    end
                end
                S_GAP: begin
                    if (rise_stb) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(GAP_CLKS - 1)) begin
                            state_q <= S_IDLE;
                        end
                    end
                end
                S_RESP: begin
                    if (tmo_hit) begin
                        state_q <= S_IDLE;
                    end else if (rx_done) begin
                        state_q <= (!rx_crc_bad && kind_q == KIND_R1B) ? S_RELW : S_IDLE;
                    end else if (rise_stb && !rx_started && cmd_in) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_RELW: begin
                    if (rise_stb && dat0_in) begin
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Hold the most recent argument (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0;
        end else if (arg_wr) begin
            arg_q <= arg_data;
        end
    end

    // Sticky status flags, cleared by a read (R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_word <= '0;
        end else begin
            stat_word <= (status_rd ? 4'b0 : stat_word) | set_bits;
        end
    end

    // Response words: long tokens fill all four, short ones only word 0 (R6, R7).
    for (genvar g = 0; g < N_WORDS; g++) begin : g_resp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                resp_q[g] <= '0;
            end else if ((state_q == S_RESP) && rx_done && !abort) begin
                if (kind_q == KIND_R2) begin
                    resp_q[g] <= token[32*g +: 32];
                end else if (g == 0) begin
                    resp_q[g] <= token[39:8];
                end
            end
        end
    end

    assign resp0 = resp_q[0];
    assign resp1 = resp_q[1];
    assign resp2 = resp_q[2];
    assign resp3 = resp_q[3];

    // Controller status: any busy, command busy, release-wait busy (R4, R10).
    always_comb begin
        ctl_sta    = '0;
        ctl_sta[1] = (state_q == S_SEND) || (state_q == S_GAP) || (state_q == S_RESP);
        ctl_sta[4] = (state_q == S_RELW);
        ctl_sta[0] = ctl_sta[1] || ctl_sta[4];
    end

endmodule

// File: rtl/sdcmd_engine_chk.sv
// Protocol checker for the command engine, bound to every instance.
// Assumes the strobe inputs never coincide.
module sdcmd_engine_chk
    import sdcmd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_wr,
    input logic [CW_W-1:0] cmd_word,
    input logic            status_rd,
    input logic            rise_stb,
    input logic            fall_stb,
    input logic            dat0_in,
    input logic            cmd_oe,
    input logic            cmd_out,
    input logic [3:0]      stat_word,
    input logic [4:0]      ctl_sta
);

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_sta[0] && cmd_wr) |=> ctl_sta[1]); // R4

    AST_OE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> ctl_sta[1]); // R3

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oe && !fall_stb && !cmd_wr) |=> ($stable(cmd_out) && cmd_oe)); // R3

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[ST_READY]) |-> !ctl_sta[0]); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !ctl_sta[0]) |=> (stat_word == 4'b0)); // R12

    AST_RELW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sta[4] |-> (!ctl_sta[1] && !cmd_oe)); // R10

    AST_RELW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sta[4] && !(rise_stb && dat0_in) && !(cmd_wr && cmd_word[CW_BRK]))
        |=> ctl_sta[4]); // R10

    AST_TMO_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[ST_TMO]) |-> !$rose(stat_word[ST_READY])); // R9

    AST_UNUSED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sta[3:2] == 2'b00); // R4

endmodule

bind sdcmd_engine sdcmd_engine_chk u_sdcmd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_word  (cmd_word),
    .status_rd (status_rd),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .dat0_in   (dat0_in),
    .cmd_oe    (cmd_oe),
    .cmd_out   (cmd_out),
    .stat_word (stat_word),
    .ctl_sta   (ctl_sta)
);

// File: tb/test_sdcmd_engine.sv
`timescale 1ns/1ps
module test_sdcmd_engine;

    localparam int TO_CLKS  = 16;
    localparam int GAP_CLKS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rise_stb, fall_stb;
    logic [1:0]  ph = 2'd0;
    logic        arg_wr = 1'b0;
    logic [31:0] arg_data = '0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        status_rd = 1'b0;
    logic        cmd_in = 1'b1;
    logic        dat0_in = 1'b1;
    logic        cmd_out, cmd_oe;
    logic [3:0]  stat_word;
    logic [4:0]  ctl_sta;
    logic [31:0] resp0, resp1, resp2, resp3;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int popped = 0;

    typedef struct packed {
        logic [3:0]   sta;
        logic [127:0] rr;
    } exp_t;
    exp_t        sb_q[$];
    string       tag_q[$];
    logic [31:0] model_r [4];

    always #2.5 clk = ~clk;

    // Divider stand-in: rise at phase 0, fall at phase 2.
    always_ff @(posedge clk) ph <= ph + 2'd1;
    assign rise_stb = (ph == 2'd0);
    assign fall_stb = (ph == 2'd2);

    sdcmd_engine #(.TO_CLKS(TO_CLKS), .GAP_CLKS(GAP_CLKS)) i_sdcmd_engine (
        .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .arg_wr(arg_wr), .arg_data(arg_data), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .status_rd(status_rd), .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .stat_word(stat_word), .ctl_sta(ctl_sta),
        .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Bench checksum, generator-constant form.
    function automatic logic [6:0] bcrc(input logic [135:0] d, input int hi, input int lo);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = hi; i >= lo; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] pl,
                                              input bit bad);
        logic [135:0] t;
        t = '0;
        t[47:8] = {2'b00, idx, pl};
        t[7:1]  = bcrc(t, 47, 8) ^ (bad ? 7'h01 : 7'h00);
        t[0]    = 1'b1;
        return t;
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] body);
        logic [135:0] t;
        t = '0;
        t[135:128] = 8'h3F;
        t[127:8]   = body;
        t[7:1]     = bcrc(t, 127, 8);
        t[0]       = 1'b1;
        return t;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [135:0] t;
        t = '0;
        t[47:8] = {2'b01, idx, arg};
        t[7:1]  = bcrc(t, 47, 8);
        t[0]    = 1'b1;
        return t[47:0];
    endfunction

    task automatic push(input logic [3:0] sta, input string tag);
        exp_t e;
        e.sta = sta;
        e.rr  = {model_r[3], model_r[2], model_r[1], model_r[0]};
        sb_q.push_back(e);
        tag_q.push_back(tag);
        pushed++;
    endtask

    task automatic wait_fall();
        do @(negedge clk); while (!fall_stb);
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] kind);
        @(negedge clk);
        arg_wr = 1'b1; arg_data = arg;
        @(negedge clk);
        arg_wr = 1'b0;
        cmd_wr = 1'b1; cmd_word = {6'b0, kind, 1'b0, idx};
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(ctl_sta[1] && ctl_sta[0], "R4 busy after launch", ctl_sta, 5'h03);
    endtask

    // Collect 48 frame bits on rising strobes, then check the release (R3).
    task automatic capture(output logic [47:0] f);
        int n = 0;
        f = '0;
        while (n < 48) begin
            @(negedge clk);
            if (rise_stb && cmd_oe) begin
                f = {f[46:0], cmd_out};
                n++;
            end
        end
        wait_fall();
        @(negedge clk);
        chk(!cmd_oe, "R3 line released after 48 bits", cmd_oe, 0);
    endtask

    task automatic reply(input logic [135:0] tok, input int nbits, input int dly);
        for (int i = 0; i < dly; i++) wait_fall();
        for (int i = nbits - 1; i >= 0; i--) begin
            wait_fall();
            cmd_in = tok[i];
        end
        wait_fall();
        cmd_in = 1'b1;
    endtask

    task automatic wait_idle();
        while (popped != pushed) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Scoreboard monitor: on every end of busy, compare and clear status.
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !ctl_sta[0]) begin
                exp_t  e;
                string tg;
                if (sb_q.size() == 0) begin
                    chk(0, "scoreboard underflow", 0, 1);
                end else begin
                    e  = sb_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(stat_word == e.sta, {tg, " status"}, stat_word, e.sta);
                    chk({resp3, resp2, resp1, resp0} == e.rr, {tg, " response"},
                        {resp3, resp2, resp1, resp0}, e.rr);
                    status_rd = 1'b1;
                    @(negedge clk);
                    status_rd = 1'b0;
                    chk(stat_word == 4'b0, "R12 read clears status", stat_word, 0);
                    popped++;
                end
            end
            prev = ctl_sta[0];
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        logic [47:0]  f;
        logic [135:0] tk;
        int           n;
        for (int i = 0; i < 4; i++) model_r[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_word == 0 && ctl_sta == 0 && !cmd_oe && cmd_out,
            "reset state", {stat_word, ctl_sta, cmd_oe, cmd_out}, 1);

        // R5 / R2: no-response command with a known frame.
        push(4'b0001, "R5 no response");
        issue(6'd0, 32'h0, 3'd0);
        capture(f);
        chk(f == 48'h400000000095, "R2 frame for index 0", f, 48'h400000000095);
        n = 0;
        while (ctl_sta[0]) begin
            @(negedge clk);
            if (rise_stb && ctl_sta[0]) n++;
        end
        chk(n == GAP_CLKS, "R5 idle gap length", n, GAP_CLKS);
        wait_idle();

        // R6 / R1: short response, argument written twice before launch.
        @(negedge clk); arg_wr = 1'b1; arg_data = 32'hDEAD0000;
        model_r[0] = 32'hCAFE1234;
        push(4'b0001, "R6 short response");
        issue(6'd17, 32'h00001200, 3'd1);
        capture(f);
        chk(f == exp_frame(6'd17, 32'h00001200), "R1 latest argument in frame",
            f, exp_frame(6'd17, 32'h00001200));
        reply(mk_short(6'd17, 32'hCAFE1234, 0), 48, 2);
        wait_idle();

        // R7: long response into four words.
        tk = mk_long(120'h0102030405060708090A0B0C0D0E0F);
        model_r[0] = tk[31:0]; model_r[1] = tk[63:32];
        model_r[2] = tk[95:64]; model_r[3] = tk[127:96];
        push(4'b0001, "R7 long response");
        issue(6'd2, 32'h0, 3'd2);
        capture(f);
        chk(f == exp_frame(6'd2, 32'h0), "R2 frame checksum", f, exp_frame(6'd2, 32'h0));
        reply(tk, 136, 3);
        wait_idle();

        // R6: short response keeps words 1 to 3.
        model_r[0] = 32'h00000900;
        push(4'b0001, "R6 upper words kept");
        issue(6'd13, 32'h55AA55AA, 3'd6);
        capture(f);
        reply(mk_short(6'd13, 32'h00000900, 0), 48, 2);
        wait_idle();

        // R8: kind 3 with a wrong checksum is accepted.
        model_r[0] = 32'h80FF8000;
        push(4'b0001, "R8 kind 3 skips check");
        issue(6'd41, 32'h00300000, 3'd3);
        capture(f);
        reply(mk_short(6'd63, 32'h80FF8000, 1), 48, 2);
        wait_idle();

        // R8: kind 1 with a wrong checksum.
        model_r[0] = 32'h12345678;
        push(4'b0100, "R8 checksum error");
        issue(6'd7, 32'h0, 3'd1);
        capture(f);
        reply(mk_short(6'd7, 32'h12345678, 1), 48, 2);
        wait_idle();

        // R9: no response at all.
        push(4'b0010, "R9 timeout");
        issue(6'd8, 32'h000001AA, 3'd1);
        capture(f);
        wait_idle();

        // R10: release wait on DAT0.
        model_r[0] = 32'h00000B00;
        push(4'b0001, "R10 release wait");
        issue(6'd12, 32'h0, 3'd7);
        capture(f);
        dat0_in = 1'b0;
        reply(mk_short(6'd12, 32'h00000B00, 0), 48, 2);
        repeat (12) @(negedge clk);
        chk(ctl_sta[4] && !ctl_sta[1] && ctl_sta[0], "R10 release-wait busy", ctl_sta, 5'h11);
        repeat (40) @(negedge clk);
        chk(ctl_sta[4] && stat_word == 0, "R10 still waiting on DAT0",
            {ctl_sta, stat_word}, 9'h110);
        dat0_in = 1'b1;
        wait_idle();

        // R11: card interrupt response.
        model_r[0] = 32'h00A5A500;
        push(4'b1001, "R11 card interrupt");
        issue(6'd40, 32'h0, 3'd5);
        capture(f);
        reply(mk_short(6'd40, 32'h00A5A500, 0), 48, 2);
        wait_idle();

        // R13: write while busy without abort is ignored.
        model_r[0] = 32'h0000CC00;
        push(4'b0001, "R13 ignored write");
        issue(6'd13, 32'h11112222, 3'd1);
        fork
            capture(f);
            begin
                repeat (30) @(negedge clk);
                cmd_wr = 1'b1; cmd_word = {6'b0, 3'd0, 1'b0, 6'd5};
                @(negedge clk);
                cmd_wr = 1'b0;
            end
        join
        chk(f == exp_frame(6'd13, 32'h11112222), "R13 frame unchanged",
            f, exp_frame(6'd13, 32'h11112222));
        reply(mk_short(6'd13, 32'h0000CC00, 0), 48, 2);
        wait_idle();

        // R13: abort mid-frame.
        push(4'b0000, "R13 abort");
        issue(6'd9, 32'h0, 3'd1);
        repeat (40) @(negedge clk);
        cmd_wr = 1'b1; cmd_word = {6'b0, 3'd0, 1'b1, 6'd0};
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(!cmd_oe && cmd_out && !ctl_sta[0], "R13 abort releases line",
            {cmd_oe, cmd_out, ctl_sta[0]}, 3'b010);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(stat_word == 0, "R13 no status after abort", stat_word, 0);

        summary();
    end

endmodule